// File: doc/BRIEF.md
# Odd-Polynomial Residue Linearizer

This block sits after the back-end converter of a pipelined ADC whose first stage uses an open-loop residue amplifier with a nominal gain of 8 (three effective bits plus two bits of redundancy). That amplifier compresses large residues with a cubic term. The block undoes the compression digitally. It maps every back-end code through the inverse odd series y = x + p·x³ + 3·p²·x⁵ + 12·p³·x⁷, where x is the code read as a signed fraction and p is the single nonlinearity parameter.

An estimator outside the block refines p while the converter runs, so the coefficient input may change on any cycle. Each sample takes the p value present on the edge where it is accepted and keeps that value through the whole pipeline. Samples stream in at full rate with a valid flag. The corrected word leaves a fixed number of cycles later with its own valid flag and is clamped symmetrically at the output range.

Top module: `residue_linearizer`

## Requirements
- R1: `in_data` is a signed two's-complement code D standing for x = D/2^(DW-1). `in_coef` is a signed value with PF fractional bits. `out_data` is a signed OW-bit code on the same scale as `in_data`.
- R2: Each product is rounded to nearest with ties away from zero. Powers of x are formed as x², x³=x²·x, x⁵=x³·x² and x⁷=x⁵·x², each rounded to DW-1 fractional bits. p² and p³=p²·p are rounded to PF fractional bits. The terms p·x³, p²·x⁵ and p³·x⁷ are rounded to DW-1 fractional bits. The output is x + t1 + 3·t2 + 12·t3. Example: D=1024 with p=8192 (0.5 at PF=14) gives 1224.
- R3: `out_valid` equals `in_valid` delayed by 7 clock edges. The result of a sample accepted on edge k is on `out_data` after edge k+6.
- R4: Each sample is corrected with the `in_coef` value sampled on its own accepting edge, even when `in_coef` changes on every cycle.
- R5: With p = 0 the output equals D, clamped as in R7.
- R6: For any D other than the most negative code, with the same p, the output for −D is the exact negation of the output for D.
- R7: The output saturates at ±(2^(OW-1)−1). The code −2^(OW-1) is never produced. For example, D=−2048 with p=0 yields −2047 at the defaults.
- R8: While reset is asserted and right after it, `out_valid` is 0.
- R9: With D ≥ 0 and p ≥ 0 the output is never negative.
- R10: Samples with arbitrary gaps in `in_valid` come out in order, one per accepted input, with no loss or duplication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_data | input | DW | Back-end code, signed |
| in_coef | input | PW | Nonlinearity parameter p, signed, PF fractional bits |
| out_valid | output | 1 | Corrected sample present |
| out_data | output | OW | Corrected code, signed, saturated |

## Verification
The bench changes the coefficient on every cycle of a stream. A design that latched p once per burst, or that let a later p leak into earlier stages, would mix coefficients inside one result. It drives full-scale codes with the largest positive p and the most negative input code with p zero. Wrapping instead of clamping, or a one-sided clamp, shows up there as a sign flip or as −2^(OW-1). Paired ±D inputs expose rounding that is biased toward one direction, because that breaks exact negation. Valid gaps and a hand-computed value catch a wrong latency, a dropped sample, or a coefficient of 3 or 12 applied to the wrong term.

// File: rtl/residue_linearizer.sv
module residue_linearizer #(
  parameter int DW = 12,
  parameter int PW = 16,
  parameter int PF = 14,
  parameter int OW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  input  logic signed [PW-1:0] in_coef,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data
);
  localparam int F   = DW - 1;
  localparam int IW  = DW + 1;
  localparam int P2W = 2*PW - PF;
  localparam int P3W = 3*PW - 2*PF;
  localparam int TW  = P3W + IW - PF + 1;
  localparam int MW  = P3W + IW + 4;
  localparam int LAT = 7;
  localparam logic signed [MW-1:0] OMAX = {{(MW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [MW-1:0] OMIN = -OMAX;

  function automatic logic signed [MW-1:0] mrnd(input logic signed [MW-1:0] a,
                                                 input logic signed [MW-1:0] b,
                                                 input int s);
    logic signed [MW-1:0] v, m, h;
    v = a * b;
    h = {{(MW-1){1'b0}}, 1'b1} << (s - 1);
    m = (v < 0) ? -v : v;
    m = (m + h) >>> s;
    return (v < 0) ? -m : m;
  endfunction

  logic [LAT-1:0] vp;
  logic signed [DW-1:0]  x1, x2, x3, x4, x5, x6;
  logic signed [PW-1:0]  p1, p2, p3, p4, p5, p6;
  logic signed [IW-1:0]  sq2, sq3, sq4, cu3, q5_4, q7_5;
  logic signed [P2W-1:0] pp2, pp3, pp4;
  logic signed [P3W-1:0] pc3, pc4, pc5;
  logic signed [TW-1:0]  t1_4, t1_5, t1_6, t2_5, t2_6, t3_6;

  logic signed [MW-1:0] m_sq, m_pp, m_cu, m_pc, m_q5, m_t1, m_q7, m_t2, m_t3;
  logic signed [MW-1:0] xe1, xe2, xe, t1e, t2e, t3e, acc, oext;

  assign xe1  = {{(MW-DW){x1[DW-1]}}, x1};
  assign xe2  = {{(MW-DW){x2[DW-1]}}, x2};
  assign m_sq = mrnd(xe1, xe1, F);
  assign m_pp = mrnd({{(MW-PW){p1[PW-1]}}, p1}, {{(MW-PW){p1[PW-1]}}, p1}, PF);
  assign m_cu = mrnd({{(MW-IW){sq2[IW-1]}}, sq2}, xe2, F);
  assign m_pc = mrnd({{(MW-P2W){pp2[P2W-1]}}, pp2}, {{(MW-PW){p2[PW-1]}}, p2}, PF);
  assign m_q5 = mrnd({{(MW-IW){cu3[IW-1]}}, cu3}, {{(MW-IW){sq3[IW-1]}}, sq3}, F);
  assign m_t1 = mrnd({{(MW-PW){p3[PW-1]}}, p3}, {{(MW-IW){cu3[IW-1]}}, cu3}, PF);
  assign m_q7 = mrnd({{(MW-IW){q5_4[IW-1]}}, q5_4}, {{(MW-IW){sq4[IW-1]}}, sq4}, F);
  assign m_t2 = mrnd({{(MW-P2W){pp4[P2W-1]}}, pp4}, {{(MW-IW){q5_4[IW-1]}}, q5_4}, PF);
  assign m_t3 = mrnd({{(MW-P3W){pc5[P3W-1]}}, pc5}, {{(MW-IW){q7_5[IW-1]}}, q7_5}, PF);

  assign xe  = {{(MW-DW){x6[DW-1]}}, x6};
  assign t1e = {{(MW-TW){t1_6[TW-1]}}, t1_6};
  assign t2e = {{(MW-TW){t2_6[TW-1]}}, t2_6};
  assign t3e = {{(MW-TW){t3_6[TW-1]}}, t3_6};
  assign acc = xe + t1e + (t2e <<< 1) + t2e + (t3e <<< 3) + (t3e <<< 2);
  assign oext = {{(MW-OW){out_data[OW-1]}}, out_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vp <= '0;
      x1 <= '0; x2 <= '0; x3 <= '0; x4 <= '0; x5 <= '0; x6 <= '0;
      p1 <= '0; p2 <= '0; p3 <= '0; p4 <= '0; p5 <= '0; p6 <= '0;
      sq2 <= '0; sq3 <= '0; sq4 <= '0; cu3 <= '0; q5_4 <= '0; q7_5 <= '0;
      pp2 <= '0; pp3 <= '0; pp4 <= '0; pc3 <= '0; pc4 <= '0; pc5 <= '0;
      t1_4 <= '0; t1_5 <= '0; t1_6 <= '0; t2_5 <= '0; t2_6 <= '0; t3_6 <= '0;
      out_data <= '0;
    end else begin
      vp <= {vp[LAT-2:0], in_valid};
      x1 <= in_data; p1 <= in_coef;
      x2 <= x1; p2 <= p1; sq2 <= m_sq[IW-1:0]; pp2 <= m_pp[P2W-1:0];
      x3 <= x2; p3 <= p2; sq3 <= sq2; cu3 <= m_cu[IW-1:0];
      pp3 <= pp2; pc3 <= m_pc[P3W-1:0];
      x4 <= x3; p4 <= p3; sq4 <= sq3; q5_4 <= m_q5[IW-1:0];
      t1_4 <= m_t1[TW-1:0]; pp4 <= pp3; pc4 <= pc3;
      x5 <= x4; p5 <= p4; q7_5 <= m_q7[IW-1:0]; t1_5 <= t1_4;
      t2_5 <= m_t2[TW-1:0]; pc5 <= pc4;
      x6 <= x5; p6 <= p5; t1_6 <= t1_5; t2_6 <= t2_5; t3_6 <= m_t3[TW-1:0];
      if (acc > OMAX)      out_data <= OMAX[OW-1:0];
      else if (acc < OMIN) out_data <= OMIN[OW-1:0];
      else                 out_data <= acc[OW-1:0];
    end
  end

  assign out_valid = vp[LAT-1];

  logic [2:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end

  a_r3_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 3'd7) |-> (out_valid == $past(in_valid, 7)));

  a_r7_no_min_code: assert property (@(posedge clk) disable iff (!rst_n)
    out_data != {1'b1, {(OW-1){1'b0}}});

  a_r5_zero_coef_identity: assert property (@(posedge clk) disable iff (!rst_n)
    $past(p6 == '0) |-> oext == (($past(xe) > OMAX) ? OMAX :
                                 ($past(xe) < OMIN) ? OMIN : $past(xe)));

  a_r9_nonneg_stays_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!x6[DW-1] && !p6[PW-1]) |-> !out_data[OW-1]);

  a_r8_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> !out_valid);
endmodule

// File: tb/residue_linearizer_tb.sv
module residue_linearizer_tb_top;
  localparam int DW = 12, PW = 16, PF = 14, OW = 12, LAT = 7;
  localparam int F = DW - 1;
  localparam longint OMAX = (longint'(1) << (OW-1)) - 1;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic signed [PW-1:0] in_coef = '0;
  logic out_valid;
  logic signed [OW-1:0] out_data;

  residue_linearizer #(.DW(DW), .PW(PW), .PF(PF), .OW(OW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_coef(in_coef), .out_valid(out_valid), .out_data(out_data));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  bit     pv[LAT];
  longint pd[LAT];
  longint got[$];
  longint expq[$];

  function automatic longint rs(longint v, int s);
    longint m = (v < 0) ? -v : v;
    m = (m + (longint'(1) << (s - 1))) >>> s;
    return (v < 0) ? -m : m;
  endfunction

  function automatic longint model(longint d, longint p);
    longint x2, x3, x5, x7, p2, p3, y;
    x2 = rs(d * d, F);   x3 = rs(x2 * d, F);
    x5 = rs(x3 * x2, F); x7 = rs(x5 * x2, F);
    p2 = rs(p * p, PF);  p3 = rs(p2 * p, PF);
    y = d + rs(p * x3, PF) + 3 * rs(p2 * x5, PF) + 12 * rs(p3 * x7, PF);
    if (y > OMAX) y = OMAX;
    if (y < -OMAX) y = -OMAX;
    return y;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) begin pv[i] = 1'b0; pd[i] = 0; end
    end else begin
      for (int i = LAT-1; i > 0; i--) begin pv[i] = pv[i-1]; pd[i] = pd[i-1]; end
      pv[0] = in_valid;
      pd[0] = model(longint'(in_data), longint'(in_coef));
    end
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      check(out_valid == 1'b0, "R8", longint'(out_valid), 0);
    end else begin
      check(out_valid == pv[LAT-1], "R3", longint'(out_valid), longint'(pv[LAT-1]));
      if (pv[LAT-1] && out_valid)
        check(longint'(out_data) == pd[LAT-1], "R2/R4", longint'(out_data), pd[LAT-1]);
      if (out_valid) got.push_back(longint'(out_data));
    end
  end

  task automatic send(longint d, longint p);
    in_valid = 1'b1; in_data = DW'(d); in_coef = PW'(p);
    expq.push_back(model(d, p));
    @(negedge clk);
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic clear();
    got.delete(); expq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R8", longint'(out_valid), 0);

    clear();
    send(1024, 8192); send(-1024, 8192); idle(10);
    check(got.size() == 2, "R10", got.size(), 2);
    check(got[0] == 1224, "R2", got[0], 1224);
    check(got[1] == -1224, "R6", got[1], -1224);

    clear();
    send(0, 0); send(1, 0); send(-1, 0); send(2047, 0); send(-700, 0); send(-2048, 0);
    idle(10);
    check(got[0] == 0, "R5", got[0], 0);
    check(got[1] == 1, "R1", got[1], 1);
    check(got[2] == -1, "R5", got[2], -1);
    check(got[3] == 2047, "R5", got[3], 2047);
    check(got[4] == -700, "R5", got[4], -700);
    check(got[5] == -2047, "R7", got[5], -2047);

    clear();
    send(2047, 32767); send(-2047, 32767); send(1800, 20000); idle(10);
    check(got[0] == 2047, "R7", got[0], 2047);
    check(got[1] == -2047, "R7", got[1], -2047);
    check(got[2] == 2047, "R7", got[2], 2047);

    clear();
    for (int k = 0; k < 12; k++) begin
      longint d = 37 + k * 171;
      longint p = -30000 + k * 5333;
      send(d, p); send(-d, p);
    end
    idle(10);
    for (int k = 0; k < 12; k++)
      check(got[2*k+1] == -got[2*k], "R6", got[2*k+1], -got[2*k]);

    clear();
    for (int k = 0; k < 16; k++) send((k * 613) % 2048, (k * 4099) % 32768);
    idle(10);
    for (int k = 0; k < 16; k++) check(got[k] >= 0, "R9", got[k], 0);

    clear();
    for (int k = 0; k < 40; k++) send(((k * 997) % 4096) - 2048, ((k * 7919) % 65536) - 32768);
    idle(10);
    for (int k = 0; k < 40; k++) check(got[k] == expq[k], "R4", got[k], expq[k]);

    clear();
    for (int k = 0; k < 30; k++) begin
      send(((k * 389) % 4096) - 2048, 3000 + k * 150);
      if (k % 3 == 1) idle(1);
      if (k % 7 == 2) idle(4);
    end
    idle(12);
    check(got.size() == 30, "R10", got.size(), 30);
    for (int k = 0; k < 30; k++) check(got[k] == expq[k], "R10", got[k], expq[k]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule